// File: doc/BRIEF.md
# CD Sector Stream Generator

This block emits an endless stream of synthetic 2352-byte CD-ROM sectors, one byte on each beat that the consumer accepts. The stream starts at a sector number that is loaded through a single-cycle load strobe. Every sector opens with a twelve-byte synchronisation pattern. A four-byte address header follows it: minute, second and frame as two-digit BCD, then a mode byte. The rest of the sector is zero and stands in for payload and error-correction bytes.

After the last byte of a sector the linear sector number steps by one, and the next sector starts at once with no idle beat. The consumer sees a valid/ready byte port with two markers, one for the first byte of each sector and one for the last. A load while the stream is running drops the current sector and restarts at the first byte of the newly loaded sector.

Top module: `cd_sector_gen`

## Requirements
- R1: After reset, `out_valid_o`, `out_sos_o` and `out_eos_o` are low, and they stay low until the first load.
- R2: The cycle after `load_i` is sampled high, `out_valid_o` is high and the output shows byte offset 0 of the loaded sector, with `out_sos_o` high and data 0x00.
- R3: Byte offsets 0 and 11 carry 0x00. Offsets 1 to 10 carry 0xFF.
- R4: Offset 12 carries the minute, computed as ((sector / 75) / 60) mod 100, as BCD: tens digit in bits 7:4 and units digit in bits 3:0.
- R5: Offset 13 carries the second, computed as (sector / 75) mod 60, in the same BCD form.
- R6: Offset 14 carries the frame, computed as sector mod 75, in the same BCD form.
- R7: Offset 15 carries the mode byte 0x01.
- R8: Every byte at offsets 16 to 2351 is 0x00.
- R9: While `out_valid_o` is high and `out_ready_i` is low, and no load occurs, data and markers hold their values.
- R10: `out_sos_o` is high only on offset 0 and `out_eos_o` only on offset 2351. Each appears exactly once per sector, and the two are never high together.
- R11: When the byte at offset 2351 is accepted, the next byte is offset 0 of sector number + 1. Offsets advance only on beats where valid and ready are both high.
- R12: A load takes priority over a same-cycle accepted beat, including one at the end of a sector. The next byte is offset 0 of the loaded sector, not of the incremented one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Load strobe for the start sector number |
| load_sector_i | input | 19 | Linear sector number to start from |
| out_valid_o | output | 1 | Output byte is valid |
| out_ready_i | input | 1 | Consumer accepts the byte this cycle |
| out_data_o | output | 8 | Current sector byte |
| out_sos_o | output | 1 | Marks byte offset 0 of a sector |
| out_eos_o | output | 1 | Marks byte offset 2351 of a sector |

## Verification
Two functions can fall in the same cycle: the end-of-sector wrap, which moves to offset 0 and increments the sector number, and a new load. The bench streams a full sector with ready held high. On the beat that shows offset 2351 it raises the load strobe with an unrelated sector number. It then checks that the following byte starts the loaded sector and that the header carries that sector's minute, second and frame, not those of the incremented number. A second case applies back-pressure on the last byte, to check that the wrap waits for acceptance.

// File: rtl/cd_gen_pkg.sv
package cd_gen_pkg;
  localparam int unsigned SECTOR_BYTES  = 2352;
  localparam int unsigned FRAMES_PER_S  = 75;
  localparam int unsigned SECS_PER_MIN  = 60;
  localparam int unsigned OFF_W         = $clog2(SECTOR_BYTES);
  localparam int unsigned SYNC_LAST_OFF = 11;
  localparam int unsigned HDR_MIN_OFF   = 12;
  localparam int unsigned HDR_SEC_OFF   = 13;
  localparam int unsigned HDR_FRM_OFF   = 14;
  localparam int unsigned HDR_MODE_OFF  = 15;
  localparam logic [7:0]  MODE_BYTE     = 8'h01;

  // shift-and-add-3 conversion of a value below 100 into two BCD digits
  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [14:0] s;
    s = {8'd0, v};
    for (int i = 0; i < 7; i++) begin
      if (s[10:7] >= 4'd5) s[10:7] = s[10:7] + 4'd3;
      if (s[14:11] >= 4'd5) s[14:11] = s[14:11] + 4'd3;
      s = s << 1;
    end
    return s[14:7];
  endfunction
endpackage

// File: rtl/cd_pos_counter.sv
module cd_pos_counter
  import cd_gen_pkg::*;
#(
  parameter int unsigned SECTOR_W = 19
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [SECTOR_W-1:0] load_sector_i,
  input  logic                ready_i,
  output logic                valid_o,
  output logic [OFF_W-1:0]    offset_o,
  output logic [SECTOR_W-1:0] sector_o
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(SECTOR_BYTES - 1);

  logic beat;
  logic wrap;
  assign beat = valid_o && ready_i;
  assign wrap = beat && (offset_o == LAST_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      offset_o <= '0;
      sector_o <= '0;
    end else if (load_i) begin
      valid_o  <= 1'b1;
      offset_o <= '0;
      sector_o <= load_sector_i;
    end else if (wrap) begin
      offset_o <= '0;
      sector_o <= sector_o + 1'b1;
    end else if (beat) begin
      offset_o <= offset_o + 1'b1;
    end
  end

  // R2 / R12: load restarts at offset 0 of the loaded sector
  a_r12_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (valid_o && offset_o == '0 && sector_o == $past(load_sector_i)));

  // R11: wrap moves to the next sector
  a_r11_wrap_next: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !load_i) |=> (offset_o == '0 && sector_o == $past(sector_o) + 1'b1));

  // R9: stall holds position
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i && !load_i) |=> ($stable(offset_o) && $stable(sector_o)));

  // R1: nothing valid before the first load
  a_r1_idle_until_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !load_i) |=> !valid_o);
endmodule

// File: rtl/cd_byte_select.sv
module cd_byte_select
  import cd_gen_pkg::*;
#(
  parameter int unsigned SECTOR_W = 19
) (
  input  logic [OFF_W-1:0]    offset_i,
  input  logic [SECTOR_W-1:0] sector_i,
  output logic [7:0]          byte_o
);
  logic [SECTOR_W-1:0] whole_secs;
  logic [7:0] bcd_min, bcd_sec, bcd_frm;

  assign whole_secs = sector_i / SECTOR_W'(FRAMES_PER_S);
  assign bcd_frm = to_bcd(7'(sector_i % SECTOR_W'(FRAMES_PER_S)));
  assign bcd_sec = to_bcd(7'(whole_secs % SECTOR_W'(SECS_PER_MIN)));
  assign bcd_min = to_bcd(7'((whole_secs / SECTOR_W'(SECS_PER_MIN)) % SECTOR_W'(100)));

  always_comb begin
    if (offset_i == '0 || offset_i == OFF_W'(SYNC_LAST_OFF))
      byte_o = 8'h00;
    else if (offset_i < OFF_W'(SYNC_LAST_OFF))
      byte_o = 8'hFF;
    else if (offset_i == OFF_W'(HDR_MIN_OFF))
      byte_o = bcd_min;
    else if (offset_i == OFF_W'(HDR_SEC_OFF))
      byte_o = bcd_sec;
    else if (offset_i == OFF_W'(HDR_FRM_OFF))
      byte_o = bcd_frm;
    else if (offset_i == OFF_W'(HDR_MODE_OFF))
      byte_o = MODE_BYTE;
    else
      byte_o = 8'h00;
  end
endmodule

// File: rtl/cd_sector_gen.sv
module cd_sector_gen
  import cd_gen_pkg::*;
#(
  parameter int unsigned SECTOR_W = 19
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [SECTOR_W-1:0] load_sector_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [7:0]          out_data_o,
  output logic                out_sos_o,
  output logic                out_eos_o
);
  logic [OFF_W-1:0]    offset;
  logic [SECTOR_W-1:0] sector;
  logic [7:0]          sel_byte;

  cd_pos_counter #(.SECTOR_W(SECTOR_W)) u_pos (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .load_sector_i(load_sector_i),
    .ready_i      (out_ready_i),
    .valid_o      (out_valid_o),
    .offset_o     (offset),
    .sector_o     (sector)
  );

  cd_byte_select #(.SECTOR_W(SECTOR_W)) u_sel (
    .offset_i(offset),
    .sector_i(sector),
    .byte_o  (sel_byte)
  );

  assign out_data_o = out_valid_o ? sel_byte : 8'h00;
  assign out_sos_o  = out_valid_o && (offset == '0);
  assign out_eos_o  = out_valid_o && (offset == OFF_W'(SECTOR_BYTES - 1));

  // R10: markers never coincide
  a_r10_markers_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_sos_o && out_eos_o));

  // R10 / R11: an accepted end byte is followed by a start byte
  a_r10_eos_then_sos: assert property (@(posedge clk) disable iff (!rst_n)
    (out_eos_o && out_ready_i) |=> out_sos_o);

  // R3: sync body bytes are all ones
  a_r3_sync_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && offset >= OFF_W'(1) && offset <= OFF_W'(10)) |-> (out_data_o == 8'hFF));
endmodule

// File: tb/sim_cd_sector_gen.sv
module sim_cd_sector_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [18:0] load_sector_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [7:0]  out_data_o;
  logic        out_sos_o;
  logic        out_eos_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  cd_sector_gen u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_sector_i(load_sector_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
    .out_sos_o(out_sos_o), .out_eos_o(out_eos_o)
  );

  function automatic logic [7:0] dec2(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic logic [7:0] want(input int sec, input int off);
    if (off >= 1 && off <= 10) return 8'hFF;
    case (off)
      12: return dec2((sec / 4500) % 100);
      13: return dec2((sec / 75) % 60);
      14: return dec2(sec % 75);
      15: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input int sec);
    @(negedge clk);
    load_i = 1'b1; load_sector_i = 19'(sec);
    @(negedge clk);
    load_i = 1'b0;
  endtask

  // walks one whole sector with ready high; all checks at negedge
  task automatic walk_sector(input int sec, input string tag);
    int bad = 0, sos_n = 0, eos_n = 0;
    out_ready_i = 1'b1;
    for (int off = 0; off < 2352; off++) begin
      if (out_data_o !== want(sec, off)) begin
        if (bad == 0) $display("FAIL %s sec=%0d off=%0d actual=%0h expected=%0h",
                               tag, sec, off, out_data_o, want(sec, off));
        bad++;
      end
      if (out_sos_o) begin sos_n++; if (off != 0) bad++; end
      if (out_eos_o) begin eos_n++; if (off != 2351) bad++; end
      if (off != 2351) @(negedge clk);
    end
    checks++;
    if (bad != 0 || sos_n != 1 || eos_n != 1) begin
      fails++;
      $display("FAIL %s R8 R10 sector walk sec=%0d bad=%0d sos=%0d eos=%0d expected 0/1/1",
               tag, sec, bad, sos_n, eos_n);
    end
  endtask

  task automatic t_reset;
    chk("R1 valid", out_valid_o, 0);
    chk("R1 sos", out_sos_o, 0);
    chk("R1 eos", out_eos_o, 0);
    repeat (3) @(negedge clk);
    chk("R1 still idle", out_valid_o, 0);
  endtask

  task automatic t_header(input int sec);
    out_ready_i = 1'b0;
    do_load(sec);
    chk("R2 valid", out_valid_o, 1);
    chk("R2 sos", out_sos_o, 1);
    chk("R2 data", out_data_o, 0);
    out_ready_i = 1'b1;
    for (int off = 1; off < 16; off++) begin
      @(negedge clk);
      case (off)
        11: chk("R3 offset11", out_data_o, 0);
        12: chk("R4 minute", out_data_o, want(sec, 12));
        13: chk("R5 second", out_data_o, want(sec, 13));
        14: chk("R6 frame", out_data_o, want(sec, 14));
        15: chk("R7 mode", out_data_o, 8'h01);
        default: chk("R3 sync ones", out_data_o, 8'hFF);
      endcase
    end
    out_ready_i = 1'b0;
  endtask

  task automatic t_stall;
    out_ready_i = 1'b0;
    do_load(1234);
    out_ready_i = 1'b1;
    repeat (12) @(negedge clk);        // now at offset 12
    out_ready_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 stall data", out_data_o, want(1234, 12));
    chk("R9 stall valid", out_valid_o, 1);
    out_ready_i = 1'b1;
    @(negedge clk);
    chk("R9 resume", out_data_o, want(1234, 13));
    out_ready_i = 1'b0;
  endtask

  task automatic t_wrap(input int sec);
    out_ready_i = 1'b0;
    do_load(sec);
    walk_sector(sec, "R11 first");
    out_ready_i = 1'b0;                // back-pressure on last byte
    @(negedge clk);
    chk("R11 eos held", out_eos_o, 1);
    out_ready_i = 1'b1;
    @(negedge clk);
    chk("R11 next sos", out_sos_o, 1);
    walk_sector(sec + 1, "R11 next");
    out_ready_i = 1'b0;
  endtask

  task automatic t_reload_mid;
    out_ready_i = 1'b1;
    do_load(100);
    repeat (40) @(negedge clk);
    load_i = 1'b1; load_sector_i = 19'd333333;
    @(negedge clk);
    load_i = 1'b0; out_ready_i = 1'b0;
    chk("R12 mid sos", out_sos_o, 1);
    out_ready_i = 1'b1;
    repeat (14) @(negedge clk);
    chk("R12 mid frame", out_data_o, want(333333, 14));
    out_ready_i = 1'b0;
  endtask

  task automatic t_collide;
    out_ready_i = 1'b0;
    do_load(4499);
    walk_sector(4499, "R12 pre");      // ends showing offset 2351, ready high
    load_i = 1'b1; load_sector_i = 19'd271828;
    @(negedge clk);
    load_i = 1'b0;
    chk("R12 collide sos", out_sos_o, 1);
    walk_sector(271828, "R12 collide");
    out_ready_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_reset;
    t_header(0);
    t_header(4499);
    t_header(449999);
    t_stall;
    t_wrap(74);
    t_reload_mid;
    t_collide;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule